// File: doc/BRIEF.md
# UART FIFO Control and Trigger Interrupt Logic

This block holds the FIFO control word of one UART channel whose transmit and receive FIFOs are each 64 entries deep. A host writes an 8-bit control word through a single-cycle write port. The block keeps the enable, DMA-mode and trigger-code fields, turns the two FIFO-reset bits into one-cycle clear strobes for the FIFO pointer and counter logic, and exports the DMA-mode level to the ready-pin logic elsewhere.

From the live fill counts of both FIFOs it produces registered transmit and receive interrupt requests. The receive request follows a plain threshold on the fill count. The transmit request depends on the last refill: it fires when the count falls below the trigger level, but only if a host write pushed the count above that level; otherwise it waits for the FIFO to run empty. There are two level tables, one per direction, and both directions look up their level in the table picked by the most recent control write.

Top module: `uart_fifo_trig_ctl`

## Requirements
- R1: During and after reset, with no write, the readback word, `fifoEn`, `dmaMode`, both clear strobes and both interrupt outputs are 0, both trigger codes are 0 and the transmit-direction table is selected.
- R2: A write stores bit 0 as the FIFO enable and bit 3 as DMA mode (1 = DMA, 0 = normal). Both are visible from the cycle after the write on `fifoEn`, `dmaMode` and readback bits 0 and 3.
- R3: A write with bits 0 and 2 both 1 raises `txFifoClr` for exactly the one cycle after the write, with readback bit 2 reading 1 in that cycle and 0 afterwards. A write with bit 2 set and bit 0 clear produces no strobe.
- R4: Bits 1 and 0 drive `rxFifoClr` the same way. In the cycle after the strobe, `rxIrq` is 0 regardless of the receive count.
- R5: Bits 5:4 (transmit trigger code, readback bits 5:4) are updated only when `extEn` is 1 during the write; otherwise they keep their value.
- R6: Bits 7:6 (receive trigger code, readback bits 7:6) are updated on every write.
- R7: Table selection is shared: a write with `extEn` = 1 selects the transmit table (codes 0..3 give 1, 16, 32, 56), a write with `extEn` = 0 selects the receive table (codes 0..3 give 1, 16, 56, 60); each direction uses its own code in the selected table.
- R8: `rxIrq` is 1 in the cycle after the receive count is at or above the receive level, and 0 in the cycle after it is below.
- R9: When no host push saw the transmit count above the transmit level since the flag last cleared, `txIrq` rises only after the count reaches 0.
- R10: After a host push (`txPush` = 1) with the count above the level, `txIrq` rises one cycle after the count drops below the level; that firing clears the refill flag; `txIrq` then stays 1 while the count stays below the level and falls one cycle after the count reaches it.
- R11: A `txFifoClr` strobe clears the refill flag, taking priority over a host push above the level in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Control word write strobe |
| wrData | input | 8 | Control word |
| extEn | input | 1 | Allows update of the transmit trigger code |
| txCount | input | 7 | Live transmit FIFO fill count (0..64) |
| rxCount | input | 7 | Live receive FIFO fill count (0..64) |
| txPush | input | 1 | Host writes a character into the transmit FIFO |
| ctrlRead | output | 8 | Readback of the control word |
| fifoEn | output | 1 | FIFO enable level |
| dmaMode | output | 1 | DMA mode level |
| txFifoClr | output | 1 | One-cycle transmit FIFO pointer/counter clear |
| rxFifoClr | output | 1 | One-cycle receive FIFO pointer/counter clear |
| txIrq | output | 1 | Transmit trigger interrupt request |
| rxIrq | output | 1 | Receive trigger interrupt request |

## Verification
Two functions meet in one cycle: the transmit clear strobe and a host push that finds the count above the level, which would both act on the refill flag. The bench issues a clear write and, in the strobe cycle, drives a push with a count of 20 against a level of 16; it then lowers the count to 10 and expects no transmit interrupt, which holds only if the clear won. A second pairing, the receive clear strobe against a receive count well over its level, is judged by `rxIrq` dropping for exactly one cycle.

// File: rtl/uft_pkg.sv
package uft_pkg;

  typedef struct packed {
    logic       txClr;
    logic       rxClr;
    logic       useTxTable;
    logic [1:0] txCode;
    logic [1:0] rxCode;
  } ctlBus_t;

  function automatic int txTableLevel(input int depth, input int code);
    case (code)
      0:       return 1;
      1:       return depth / 4;
      2:       return depth / 2;
      default: return depth - 8;
    endcase
  endfunction

  function automatic int rxTableLevel(input int depth, input int code);
    case (code)
      0:       return 1;
      1:       return depth / 4;
      2:       return depth - 8;
      default: return depth - 4;
    endcase
  endfunction

endpackage

// File: rtl/uft_ctrl.sv
module uft_ctrl
  import uft_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              extEn,
  output logic [WORD_W-1:0] ctrlRead,
  output logic              fifoEn,
  output logic              dmaMode,
  output ctlBus_t           ctl
);
  localparam int EN_BIT   = 0;
  localparam int RXCL_BIT = 1;
  localparam int TXCL_BIT = 2;
  localparam int DMA_BIT  = 3;
  localparam int TXC_LO   = 4;
  localparam int RXC_LO   = 6;

  logic       enReg, dmaReg, txClrReg, rxClrReg, tableTxReg;
  logic [1:0] txCodeReg, rxCodeReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg      <= 1'b0;
      dmaReg     <= 1'b0;
      txClrReg   <= 1'b0;
      rxClrReg   <= 1'b0;
      tableTxReg <= 1'b1;
      txCodeReg  <= '0;
      rxCodeReg  <= '0;
    end else begin
      txClrReg <= 1'b0;
      rxClrReg <= 1'b0;
      if (wrEn) begin
        enReg      <= wrData[EN_BIT];
        dmaReg     <= wrData[DMA_BIT];
        txClrReg   <= wrData[EN_BIT] & wrData[TXCL_BIT];
        rxClrReg   <= wrData[EN_BIT] & wrData[RXCL_BIT];
        rxCodeReg  <= wrData[RXC_LO +: 2];
        tableTxReg <= extEn;
        if (extEn) txCodeReg <= wrData[TXC_LO +: 2];
      end
    end
  end

  always_comb begin
    ctrlRead           = '0;
    ctrlRead[EN_BIT]   = enReg;
    ctrlRead[RXCL_BIT] = rxClrReg;
    ctrlRead[TXCL_BIT] = txClrReg;
    ctrlRead[DMA_BIT]  = dmaReg;
    ctrlRead[TXC_LO +: 2] = txCodeReg;
    ctrlRead[RXC_LO +: 2] = rxCodeReg;
  end

  assign fifoEn         = enReg;
  assign dmaMode        = dmaReg;
  assign ctl.txClr      = txClrReg;
  assign ctl.rxClr      = rxClrReg;
  assign ctl.useTxTable = tableTxReg;
  assign ctl.txCode     = txCodeReg;
  assign ctl.rxCode     = rxCodeReg;

  // R3: clear strobe lasts one cycle
  a_r3_tx_clr_single: assert property (@(posedge clk) disable iff (!rstN)
    ctl.txClr |=> !ctl.txClr);
  // R3: strobe only after an enabled reset write
  a_r3_tx_clr_gated: assert property (@(posedge clk) disable iff (!rstN)
    ctl.txClr |-> $past(wrEn && wrData[EN_BIT] && wrData[TXCL_BIT]));
  // R4: same gating on the receive side
  a_r4_rx_clr_gated: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rxClr |-> $past(wrEn && wrData[EN_BIT] && wrData[RXCL_BIT]));
  // R5: transmit code locked without extEn
  a_r5_tx_code_locked: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !extEn) |=> $stable(ctl.txCode));
  // R7: table follows extEn of the last write
  a_r7_table_select: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (ctl.useTxTable == $past(extEn)));

endmodule

// File: rtl/uft_datapath.sv
module uft_datapath
  import uft_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlBus_t          ctl,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  input  logic             txPush,
  output logic             txIrq,
  output logic             rxIrq
);
  localparam int NCODES = 4;

  logic [CNT_W-1:0] txLvlTab [NCODES];
  logic [CNT_W-1:0] rxLvlTab [NCODES];
  logic [CNT_W-1:0] activeTab [NCODES];

  for (genvar c = 0; c < NCODES; c++) begin : g_levels
    localparam int TX_L = txTableLevel(DEPTH, c);
    localparam int RX_L = rxTableLevel(DEPTH, c);
    assign txLvlTab[c]  = CNT_W'(TX_L);
    assign rxLvlTab[c]  = CNT_W'(RX_L);
    assign activeTab[c] = ctl.useTxTable ? txLvlTab[c] : rxLvlTab[c];
  end

  logic [CNT_W-1:0] txLevel, rxLevel;
  assign txLevel = activeTab[ctl.txCode];
  assign rxLevel = activeTab[ctl.rxCode];

  logic filledAbove;
  logic txBelow, txEmpty, fireCond;
  assign txBelow  = txCount < txLevel;
  assign txEmpty  = txCount == '0;
  assign fireCond = filledAbove ? txBelow : txEmpty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      filledAbove <= 1'b0;
      txIrq       <= 1'b0;
      rxIrq       <= 1'b0;
    end else begin
      if (ctl.txClr)                filledAbove <= 1'b0;
      else if (fireCond && !txIrq)  filledAbove <= 1'b0;
      else if (txPush && (txCount > txLevel)) filledAbove <= 1'b1;
      txIrq <= txIrq ? txBelow : fireCond;
      rxIrq <= (rxCount >= rxLevel) && !ctl.rxClr;
    end
  end

  // R4: receive clear drops the receive request
  a_r4_rx_clr_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rxClr |=> !rxIrq);
  // R8: receive request needs the count at level
  a_r8_rx_level: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> $past(rxCount >= rxLevel));
  // R11: transmit clear wins over refill
  a_r11_flag_cleared: assert property (@(posedge clk) disable iff (!rstN)
    ctl.txClr |=> !filledAbove);
  // R10: request held while the count stays below level
  a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txIrq && txBelow) |=> txIrq);
  // R9: without refill flag, rise only on empty
  a_r9_tx_empty_rule: assert property (@(posedge clk) disable iff (!rstN)
    (!txIrq && !filledAbove && !txEmpty) |=> !txIrq);

endmodule

// File: rtl/uart_fifo_trig_ctl.sv
module uart_fifo_trig_ctl
  import uft_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              extEn,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic              txPush,
  output logic [WORD_W-1:0] ctrlRead,
  output logic              fifoEn,
  output logic              dmaMode,
  output logic              txFifoClr,
  output logic              rxFifoClr,
  output logic              txIrq,
  output logic              rxIrq
);
  ctlBus_t ctl;

  uft_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .extEn    (extEn),
    .ctrlRead (ctrlRead),
    .fifoEn   (fifoEn),
    .dmaMode  (dmaMode),
    .ctl      (ctl)
  );

  uft_datapath #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .txCount (txCount),
    .rxCount (rxCount),
    .txPush  (txPush),
    .txIrq   (txIrq),
    .rxIrq   (rxIrq)
  );

  assign txFifoClr = ctl.txClr;
  assign rxFifoClr = ctl.rxClr;

endmodule

// File: tb/tb_uart_fifo_trig_ctl.sv
module tb_uart_fifo_trig_ctl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       extEn = 1'b0;
  logic [6:0] txCount = '0;
  logic [6:0] rxCount = '0;
  logic       txPush = 1'b0;
  logic [7:0] ctrlRead;
  logic       fifoEn, dmaMode, txFifoClr, rxFifoClr, txIrq, rxIrq;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  uart_fifo_trig_ctl dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .extEn(extEn),
    .txCount(txCount), .rxCount(rxCount), .txPush(txPush),
    .ctrlRead(ctrlRead), .fifoEn(fifoEn), .dmaMode(dmaMode),
    .txFifoClr(txFifoClr), .rxFifoClr(rxFifoClr), .txIrq(txIrq), .rxIrq(rxIrq)
  );

  // {wrData, extEn, rxCount, expected rxIrq, expected readback}
  localparam logic [24:0] VEC [9] = '{
    {8'h01, 1'b1, 7'd1,  1'b1, 8'h01},
    {8'h41, 1'b1, 7'd15, 1'b0, 8'h41},
    {8'h41, 1'b1, 7'd16, 1'b1, 8'h41},
    {8'h81, 1'b0, 7'd55, 1'b0, 8'h81},
    {8'h81, 1'b0, 7'd56, 1'b1, 8'h81},
    {8'hB9, 1'b1, 7'd32, 1'b1, 8'hB9},
    {8'hC9, 1'b0, 7'd59, 1'b0, 8'hF9},
    {8'hC9, 1'b0, 7'd60, 1'b1, 8'hF9},
    {8'h01, 1'b0, 7'd0,  1'b0, 8'h31}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic e);
    @(negedge clk);
    wrEn = 1'b1; wrData = d; extEn = e;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 readback", ctrlRead, 8'h00);
    chk("R1 strobes/levels", {fifoEn, dmaMode, txFifoClr, rxFifoClr, txIrq, rxIrq}, 6'b0);
    rstN = 1'b1;

    // R6 R7 R8 R5 R2: vector walk over receive levels and tables
    for (int i = 0; i < 9; i++) begin
      rxCount = VEC[i][15:9];
      wr(VEC[i][24:17], VEC[i][16]);
      chk("R5/R6/R2 readback", ctrlRead, VEC[i][7:0]);
      @(negedge clk);
      chk("R7/R8 rxIrq", rxIrq, VEC[i][8]);
    end
    chk("R2 fifoEn", fifoEn, 1'b1);

    // R2 DMA level
    wr(8'h09, 1'b0);
    chk("R2 dmaMode", dmaMode, 1'b1);

    // R9 empty rule: tx level 16 (transmit table, code 1)
    wr(8'h11, 1'b1);
    txCount = 7'd20;
    repeat (2) @(negedge clk);
    chk("R9 idle above level", txIrq, 1'b0);
    txPush = 1'b1; txCount = 7'd10;
    @(negedge clk); txPush = 1'b0;
    txCount = 7'd5;
    repeat (2) @(negedge clk);
    chk("R9 below level without refill", txIrq, 1'b0);
    txCount = 7'd0;
    @(negedge clk);
    chk("R9 empty fires", txIrq, 1'b1);

    // R10 refill rule
    txCount = 7'd20;
    @(negedge clk);
    chk("R10 refill clears irq", txIrq, 1'b0);
    txPush = 1'b1;
    @(negedge clk); txPush = 1'b0;
    txCount = 7'd15;
    @(negedge clk);
    chk("R10 fire below level", txIrq, 1'b1);
    txCount = 7'd3;
    @(negedge clk);
    chk("R10 hold while below", txIrq, 1'b1);
    txCount = 7'd16;
    @(negedge clk);
    chk("R10 drop at level", txIrq, 1'b0);
    txCount = 7'd15;
    repeat (2) @(negedge clk);
    chk("R10 flag consumed by fire", txIrq, 1'b0);

    // R11 and R3: clear strobe against push in the same cycle
    wr(8'h15, 1'b1);
    chk("R3 txFifoClr pulse", txFifoClr, 1'b1);
    chk("R3 readback bit2 set", ctrlRead, 8'h15);
    txPush = 1'b1; txCount = 7'd20;
    @(negedge clk); txPush = 1'b0;
    chk("R3 txFifoClr single", txFifoClr, 1'b0);
    chk("R3 readback self-clear", ctrlRead, 8'h11);
    txCount = 7'd10;
    repeat (2) @(negedge clk);
    chk("R11 clear beats push", txIrq, 1'b0);

    // R4 receive clear
    rxCount = 7'd60;
    repeat (2) @(negedge clk);
    chk("R8 rx above level", rxIrq, 1'b1);
    wr(8'h03, 1'b0);
    chk("R4 rxFifoClr pulse", rxFifoClr, 1'b1);
    chk("R4 readback bit1", ctrlRead, 8'h13);
    @(negedge clk);
    chk("R4 rxIrq forced low", rxIrq, 1'b0);
    chk("R4 rxFifoClr single", rxFifoClr, 1'b0);
    @(negedge clk);
    chk("R4 rxIrq returns", rxIrq, 1'b1);

    // R3 negative: reset bit without enable
    wr(8'h14, 1'b1);
    chk("R3 no strobe without enable", txFifoClr, 1'b0);
    chk("R3 readback no enable", ctrlRead, 8'h10);

    done = 1'b1;
    finishRun();
  end
endmodule